// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM receives an auto-refresh command and keeps host traffic out of the way while that happens. A down-counter is reloaded from a programmable period input, and each time it expires a refresh is marked as owed. The row to refresh is chosen and advanced inside the memory, so the block only has to emit the command at the right moment. If a bank is still open when the refresh is owed, the block first closes all banks and waits the row-precharge time. After issuing the auto-refresh it blocks further activity for the full refresh cycle time.

A host that asks for the memory while a refresh is owed or running is held off with a wait output until the block grants it. A burst that was already granted runs to its end before the owed refresh goes out. If the owed refresh has still not been issued when the counter expires again, a sticky error flag rises. A read strobe on the status register clears the flag.

Top module: `sdr_refresh_sched`

## Requirements
- R1: With a nonzero period P written while the timer is idle (period previously zero), the first auto-refresh appears on `cmd_o` P+1 cycles after the cycle the period is applied. Later auto-refreshes follow every P cycles while nothing delays them.
- R2: A period value of zero stops the timer, and no auto-refresh command is issued.
- R3: Command encoding on `cmd_o` is 0 = no operation, 1 = precharge all banks, 2 = auto-refresh. With all banks closed, the auto-refresh goes out the cycle after the timer expires.
- R4: If `bank_open_i` is high when a refresh is owed, a precharge-all is issued first, and the auto-refresh follows exactly T_RP (default 3) cycles later.
- R5: After an auto-refresh in cycle s, `refresh_busy_o` is high from s+1 to s+T_RC-1 and no grant is given before cycle s+T_RC (default 8).
- R6: A host request that is not granted in a cycle raises `host_wait_o` in that cycle. A request made while the block is idle and no refresh is owed is granted in the same cycle.
- R7: An owed refresh wins over a new host request in the same cycle. A granted burst keeps its grant while `host_req_i` stays high, even with a refresh owed, and the owed refresh is issued the cycle after the burst is released.
- R8: A timer expiry while a refresh is still owed, and not being issued in that cycle, sets `refresh_err_o` from the next cycle.
- R9: `refresh_err_o` stays high until a cycle with `status_rd_i` high and then clears. If a new error and a read fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_period_i | input | PERIOD_W | Cycles between refreshes; zero disables the timer |
| bank_open_i | input | 1 | High while any bank is open |
| host_req_i | input | 1 | Host requests the memory; held for the whole burst |
| host_gnt_o | output | 1 | Host owns the memory this cycle |
| host_wait_o | output | 1 | Host request is being held off |
| status_rd_i | input | 1 | Status register read strobe; clears the error |
| refresh_err_o | output | 1 | Sticky missed-refresh error interrupt |
| cmd_o | output | 2 | Command: 0 nop, 1 precharge all, 2 auto-refresh |
| refresh_busy_o | output | 1 | Precharge wait or refresh cycle in progress |

## Verification
Two functions compete for a single cycle. One is the refresh that falls owed, and the other is a host request that arrives in that same cycle or in the cycle just before it, when the timer expires. The bench finds a steady refresh instant and then sweeps the request start across each offset of the period. From the tick arithmetic it computes whether the request must be granted at once, held until the refresh cycle ends, or allowed to push the refresh back. The missed-refresh flag and its read-to-clear are also made to meet: the status read is placed in the exact cycle of the second expiry, and the flag must survive that read.

// File: rtl/sdr_refsched_pkg.sv
package sdr_refsched_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_AREF = 2'd2
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOST  = 2'd1,
    ST_PRECH = 2'd2,
    ST_REFR  = 2'd3
  } seq_st_e;

  // Timer step: zero period parks the counter, expiry reloads it.
  function automatic int unsigned timer_next(int unsigned cur, int unsigned period);
    if (period == 0) return 0;
    if (cur <= 1) return period;
    return cur - 1;
  endfunction

  // An expiry always leaves a refresh owed; issuing one pays it off.
  function automatic logic pend_next(logic pend, logic tick, logic aref);
    return tick | (pend & ~aref);
  endfunction

  // A new miss outranks the read-to-clear.
  function automatic logic err_next(logic err, logic miss, logic rd);
    return miss | (err & ~rd);
  endfunction

endpackage

// File: rtl/sdr_refsched_timer.sv
module sdr_refsched_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= PERIOD_W'(sdr_refsched_pkg::timer_next(32'(cnt_q), 32'(period_i)));
  end

  assign tick_o = (period_i != '0) && (cnt_q == PERIOD_W'(1));
endmodule

// File: rtl/sdr_refsched_track.sv
module sdr_refsched_track (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic aref_i,
  input  logic rd_i,
  output logic pend_o,
  output logic miss_o,
  output logic err_o
);
  logic pend_q, err_q;

  assign miss_o = tick_i & pend_q & ~aref_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= sdr_refsched_pkg::pend_next(pend_q, tick_i, aref_i);
      err_q  <= sdr_refsched_pkg::err_next(err_q, miss_o, rd_i);
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;
endmodule

// File: rtl/sdr_refsched_seq.sv
module sdr_refsched_seq
  import sdr_refsched_pkg::*;
#(
  parameter int T_RP = 3,
  parameter int T_RC = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pend_i,
  input  logic     bank_open_i,
  input  logic     host_req_i,
  output sdr_cmd_e cmd_o,
  output logic     aref_o,
  output logic     host_gnt_o,
  output logic     host_wait_o,
  output logic     busy_o
);
  localparam int WW = $clog2(T_RP + T_RC) + 1;
  localparam logic [WW-1:0] RP_LOAD = WW'(T_RP - 1);
  localparam logic [WW-1:0] RC_LOAD = WW'(T_RC - 2);

  seq_st_e       st_q, st_d;
  logic [WW-1:0] w_q, w_d;

  always_comb begin
    st_d       = st_q;
    w_d        = w_q;
    cmd_o      = CMD_NOP;
    aref_o     = 1'b0;
    host_gnt_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pend_i) begin
          if (bank_open_i) begin
            cmd_o = CMD_PALL;
            st_d  = ST_PRECH;
            w_d   = RP_LOAD;
          end else begin
            cmd_o  = CMD_AREF;
            aref_o = 1'b1;
            st_d   = ST_REFR;
            w_d    = RC_LOAD;
          end
        end else if (host_req_i) begin
          host_gnt_o = 1'b1;
          st_d       = ST_HOST;
        end
      end
      ST_HOST: begin
        if (host_req_i) host_gnt_o = 1'b1;
        else st_d = ST_IDLE;
      end
      ST_PRECH: begin
        if (w_q == '0) begin
          cmd_o  = CMD_AREF;
          aref_o = 1'b1;
          st_d   = ST_REFR;
          w_d    = RC_LOAD;
        end else begin
          w_d = w_q - 1'b1;
        end
      end
      ST_REFR: begin
        if (w_q == '0) st_d = ST_IDLE;
        else w_d = w_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      w_q  <= '0;
    end else begin
      st_q <= st_d;
      w_q  <= w_d;
    end
  end

  assign host_wait_o = host_req_i & ~host_gnt_o;
  assign busy_o      = (st_q == ST_PRECH) || (st_q == ST_REFR);
endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched #(
  parameter int PERIOD_W = 16,
  parameter int T_RP     = 3,
  parameter int T_RC     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] refresh_period_i,
  input  logic                bank_open_i,
  input  logic                host_req_i,
  output logic                host_gnt_o,
  output logic                host_wait_o,
  input  logic                status_rd_i,
  output logic                refresh_err_o,
  output logic [1:0]          cmd_o,
  output logic                refresh_busy_o
);
  import sdr_refsched_pkg::*;

  logic     tick_w;
  logic     pend_w;
  logic     miss_w;
  logic     aref_w;
  sdr_cmd_e cmd_w;

  sdr_refsched_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (refresh_period_i),
    .tick_o   (tick_w)
  );

  sdr_refsched_track u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_w),
    .aref_i (aref_w),
    .rd_i   (status_rd_i),
    .pend_o (pend_w),
    .miss_o (miss_w),
    .err_o  (refresh_err_o)
  );

  sdr_refsched_seq #(.T_RP(T_RP), .T_RC(T_RC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend_w),
    .bank_open_i (bank_open_i),
    .host_req_i  (host_req_i),
    .cmd_o       (cmd_w),
    .aref_o      (aref_w),
    .host_gnt_o  (host_gnt_o),
    .host_wait_o (host_wait_o),
    .busy_o      (refresh_busy_o)
  );

  assign cmd_o = cmd_w;
endmodule

// File: rtl/sdr_refsched_chk.sv
module sdr_refsched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_w,
  input logic       pend_w,
  input logic       miss_w,
  input logic       aref_w,
  input logic       host_req_i,
  input logic       host_gnt_o,
  input logic       status_rd_i,
  input logic       refresh_err_o,
  input logic [1:0] cmd_o,
  input logic       refresh_busy_o
);
  // R5: no grant during the precharge wait or the refresh cycle
  a_r5_no_gnt_busy: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_busy_o |-> !host_gnt_o);

  // R5: an auto-refresh opens a busy window
  a_r5_aref_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'd2) |=> refresh_busy_o);

  // R7: a granted burst keeps its grant while held
  a_r7_burst_kept: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt_o |=> (host_req_i -> host_gnt_o));

  // R8: a missed refresh raises the error flag
  a_r8_miss_sets: assert property (@(posedge clk) disable iff (!rst_n)
    miss_w |=> refresh_err_o);

  // R9: sticky until read
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_err_o && !status_rd_i) |=> refresh_err_o);

  // R9: read clears when no new miss arrives
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd_i && !miss_w) |=> !refresh_err_o);

  // R3: issuing the refresh pays off the owed one
  a_r3_aref_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (aref_w && !tick_w) |=> !pend_w);
endmodule

bind sdr_refresh_sched sdr_refsched_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick_w         (tick_w),
  .pend_w         (pend_w),
  .miss_w         (miss_w),
  .aref_w         (aref_w),
  .host_req_i     (host_req_i),
  .host_gnt_o     (host_gnt_o),
  .status_rd_i    (status_rd_i),
  .refresh_err_o  (refresh_err_o),
  .cmd_o          (cmd_o),
  .refresh_busy_o (refresh_busy_o)
);

// File: tb/sdr_refresh_sched_bench.sv
`timescale 1ns/1ps
module sdr_refresh_sched_bench;
  localparam int PW  = 16;
  localparam int TRP = 3;
  localparam int TRC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] period = '0;
  logic          bank_open = 1'b0;
  logic          host_req = 1'b0;
  logic          status_rd = 1'b0;
  logic          host_gnt, host_wait, refresh_err, refresh_busy;
  logic [1:0]    cmd;

  int n_vec = 0;
  int n_bad = 0;
  int slot  = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) slot <= slot + 1;

  sdr_refresh_sched #(.PERIOD_W(PW), .T_RP(TRP), .T_RC(TRC)) u_sdr_refresh_sched (
    .clk              (clk),
    .rst_n            (rst_n),
    .refresh_period_i (period),
    .bank_open_i      (bank_open),
    .host_req_i       (host_req),
    .host_gnt_o       (host_gnt),
    .host_wait_o      (host_wait),
    .status_rd_i      (status_rd),
    .refresh_err_o    (refresh_err),
    .cmd_o            (cmd),
    .refresh_busy_o   (refresh_busy)
  );

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s slot=%0d actual=%0d expected=%0d", req, slot, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic find_cmd(int code, output int at);
    at = -1;
    for (int i = 0; i < 300; i++) begin
      if (int'(cmd) == code) begin
        at = slot;
        return;
      end
      @(negedge clk);
    end
  endtask

  // Park the timer at zero, then apply p; returns the apply slot.
  task automatic enable(int p, output int k);
    period = '0;
    step(TRC + 4);
    period = PW'(p);
    k = slot;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int k, s, t, g, nxt, cnt, o, p;
    step(3);
    chk("R3 reset cmd", int'(cmd), 0);
    chk("R9 reset err", int'(refresh_err), 0);
    chk("R6 reset wait", int'(host_wait), 0);
    rst_n = 1'b1;
    step(1);
    chk("R5 reset busy", int'(refresh_busy), 0);
    chk("R6 reset gnt", int'(host_gnt), 0);

    // R1 / R3: period sweep with banks closed and no host
    for (int pp = TRC; pp <= TRC + 7; pp++) begin
      enable(pp, k);
      find_cmd(2, s);
      chk("R1 first refresh", s, k + pp + 1);
      for (int r = 0; r < 2; r++) begin
        step(1);
        find_cmd(2, t);
        chk("R1 refresh interval", t - s, pp);
        s = t;
      end
      chk("R8 no error at legal period", int'(refresh_err), 0);
    end

    // R2: zero period stops refresh
    period = '0;
    step(TRC + 4);
    cnt = 0;
    for (int i = 0; i < 80; i++) begin
      if (cmd != 2'd0) cnt++;
      step(1);
    end
    chk("R2 no command while disabled", cnt, 0);

    // R4 / R5: open bank, precharge first, then refresh, then busy window
    bank_open = 1'b1;
    enable(12, k);
    find_cmd(1, t);
    chk("R4 precharge slot", t, k + 13);
    step(1);
    find_cmd(2, s);
    chk("R4 precharge to refresh gap", s - t, TRP);
    bank_open = 1'b0;
    step(1);
    chk("R5 busy after refresh", int'(refresh_busy), 1);
    step(TRC - 2);
    chk("R5 busy at last refresh cycle", int'(refresh_busy), 1);
    step(1);
    chk("R5 busy drops", int'(refresh_busy), 0);

    // R6 / R7: host request start swept across the period
    p = 12;
    for (int oo = 0; oo <= p; oo++) begin
      o = oo;
      enable(p, k);
      find_cmd(2, s);
      step(o);
      host_req = 1'b1;
      #0.1;
      if (o < TRC || o == p) begin
        chk("R6 wait asserted", int'(host_wait), 1);
        chk("R6 no grant yet", int'(host_gnt), 0);
      end else begin
        chk("R6 immediate grant", int'(host_gnt), 1);
      end
      if (o == p) chk("R7 refresh beats request", int'(cmd), 2);
      g = -1;
      for (int i = 0; i < 40; i++) begin
        if (host_gnt) begin
          g = slot;
          break;
        end
        step(1);
      end
      if (o < TRC) chk("R5 grant at end of refresh", g, s + TRC);
      else if (o == p) chk("R5 grant after second refresh", g, s + p + TRC);
      else chk("R6 grant slot", g, s + o);
      step(3);
      host_req = 1'b0;
      step(1);
      find_cmd(2, t);
      nxt = (o == p) ? s + 2 * p : s + p;
      if (g + 4 > nxt) nxt = g + 4;
      chk("R7 refresh after burst", t, nxt);
      chk("R8 no error on short burst", int'(refresh_err), 0);
    end

    // R7 / R8 / R9: burst covers two expiries, read meets the second
    p = 10;
    enable(p, k);
    find_cmd(2, s);
    step(p - 1);
    host_req = 1'b1;
    #0.1;
    chk("R6 grant at tick slot", int'(host_gnt), 1);
    step(6);
    chk("R7 burst keeps grant with refresh owed", int'(host_gnt), 1);
    chk("R7 no refresh during burst", int'(cmd), 0);
    step(p - 6);
    chk("R9 err low before second expiry", int'(refresh_err), 0);
    status_rd = 1'b1;
    step(1);
    status_rd = 1'b0;
    chk("R9 set wins over read", int'(refresh_err), 1);
    chk("R8 error raised", int'(refresh_err), 1);
    step(1);
    chk("R9 error sticky", int'(refresh_err), 1);
    status_rd = 1'b1;
    step(1);
    status_rd = 1'b0;
    chk("R9 read clears", int'(refresh_err), 0);
    host_req = 1'b0;
    step(1);
    chk("R7 refresh after long burst", int'(cmd), 2);
    chk("R7 refresh slot", slot, s + 2 * p + 3);
    step(20);
    chk("R9 stays clear", int'(refresh_err), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule